// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound DMA path of a host bridge. Each request carries a 64-bit address as seen on the downstream bus and the number (0 or 1) of the downstream port it arrived on. The block sorts the address into one of five windows. These are a 64-bit direct window, a 32-bit direct window, a 32-bit paged window, a 40-bit paged window and a 40-bit super-page window. Any address outside all five is a fault.

Each window has its own translation. The 64-bit direct window passes the low 54 bits through. The 32-bit direct window splices the low 30 address bits under a per-port base register. The three paged windows look up a translation entry, use its page address and keep the in-page offset. Where a window carries a barrier attribute, that bit is removed from the address and reported as a separate flag.

Software loads the two per-port base registers and the two entry tables through a write port. A narrow table serves both the 32-bit paged window and the super-page window. Its low 64 entries hold super pages, 32 per port. A wide table serves the 40-bit paged window. Requests and responses each use a valid/ready handshake. A response appears one cycle after the request is accepted.

Top module: `dma_inbound_xlate`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. Its response is presented on the next cycle with `rsp_valid` high. `req_ready` is high whenever no response is pending or `rsp_ready` is high. A pending response holds all of its outputs stable until `rsp_ready` takes it.
- R2: An address with bit 63 set returns bits 53:0 zero-extended. Bit 62 is reported as the barrier and bit 61 as the MSI flag. If any of bits 60:54 is nonzero, the request faults.
- R3: An address from 0x8000_0000 to 0xFFFF_FFFF returns {base[63:30], addr[29:0]}, where base is the base register of the request's port. Bit 30 is reported as the barrier. If base[63:30] is all zero, the request faults.
- R4: An address from 0 to 0x7FFF_FFFF uses 256 KB pages. Bit 30 is the barrier. The page number addr[29:18] selects narrow entry 64 + page, and addr[17:0] is the offset. A page number of at least M32_ENTRIES faults.
- R5: An address from 0x40_0000_0000 to 0x7F_FFFF_FFFF uses 64 MB pages. The page number addr[37:26] selects a wide entry, and addr[25:0] is the offset. The barrier is 0. A page number of at least M40_ENTRIES faults.
- R6: An address from 0x80_0000_0000 to 0xFF_FFFF_FFFF uses 16 GB pages. The page number addr[38:34] selects narrow entry port*32 + page, and addr[33:0] is the offset. The barrier is 0.
- R7: A translation entry is valid only when its bit 63 is set. The page address is entry bits 53:0 with the bits below the page size forced to zero. The result is the page address OR the offset. A lookup that hits an invalid entry faults.
- R8: An address with bit 63 clear that lies in none of the windows above faults. This covers 0x1_0000_0000 to 0x3F_FFFF_FFFF and anything at or above 0x100_0000_0000.
- R9: A faulting response returns address 0, barrier 0 and MSI 0.
- R10: A write with `wr_en` high takes effect at the clock edge. `wr_tgt` selects the target: 0 for a base register (port = `wr_idx[0]`), 1 for the narrow table, 2 for the wide table. `wr_idx` gives the entry number. A `wr_tgt` of 3 changes nothing. A request accepted in the same cycle as a write sees the old contents.
- R11: After reset, no response is pending, `req_ready` is high, and every base register and table entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_port | input | 1 | Downstream port of the request |
| req_addr | input | 64 | Bus address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | 64 | Translated system address |
| rsp_barrier | output | 1 | Barrier attribute |
| rsp_msi | output | 1 | MSI flag (64-bit direct only) |
| rsp_fault | output | 1 | Translation fault |
| wr_en | input | 1 | Configuration write strobe |
| wr_tgt | input | 2 | Write target select |
| wr_idx | input | IDX_W | Entry or port number |
| wr_data | input | 64 | Write data |

## Verification
Two pairs of events can share a cycle. The first pair is a table write and a lookup of the same entry. The bench rewrites a 32-bit paged entry in the very cycle a request for that page is accepted. It expects the response to carry the old page address and the next lookup to carry the new one. The second pair is draining a stalled response while accepting a new request. The bench holds `rsp_ready` low over a pending response, checks that `req_ready` drops and the output stays frozen, then raises `rsp_ready` with a second request waiting. It expects the second translation on the very next cycle.

// File: rtl/inx_pkg.sv
package inx_pkg;

    // Super-page region: two ports times 32 pages of 16 GB
    localparam int SUPER_PER_PORT = 32;
    localparam int SUPER_ENTRIES  = 2 * SUPER_PER_PORT;

    localparam int M32_SHIFT   = 18;
    localparam int M40_SHIFT   = 26;
    localparam int SUPER_SHIFT = 34;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_D64,
        WIN_D32,
        WIN_M32,
        WIN_M40,
        WIN_M40S
    } win_e;

    typedef enum logic [1:0] {
        TGT_BASE   = 2'd0,
        TGT_NARROW = 2'd1,
        TGT_WIDE   = 2'd2,
        TGT_NONE   = 2'd3
    } wtgt_e;

    typedef struct packed {
        logic        vld;
        logic [63:0] addr;
        logic        bar;
        logic        msi;
        logic        flt;
    } rsp_s;

endpackage

// File: rtl/inx_decode.sv
module inx_decode
    import inx_pkg::*;
#(
    parameter int M32_ENTRIES = 64,
    parameter int M40_ENTRIES = 64,
    parameter int SH_IDX_W    = 7,
    parameter int WD_IDX_W    = 6
) (
    input  logic [63:0]         addr,
    input  logic                port,
    output win_e                win,
    output logic                rng_flt,
    output logic [SH_IDX_W-1:0] sh_idx,
    output logic [WD_IDX_W-1:0] wd_idx,
    output logic [63:0]         offset,
    output logic [63:0]         pmask
);

    localparam logic [63:0] M32_MASK   = (64'd1 << M32_SHIFT) - 64'd1;
    localparam logic [63:0] M40_MASK   = (64'd1 << M40_SHIFT) - 64'd1;
    localparam logic [63:0] SUPER_MASK = (64'd1 << SUPER_SHIFT) - 64'd1;

    logic [11:0] m32_pg;
    logic [11:0] m40_pg;
    logic [4:0]  sup_pg;

    assign m32_pg = addr[29:18];
    assign m40_pg = addr[37:26];
    assign sup_pg = addr[38:34];

    always_comb begin
        win     = WIN_NONE;
        rng_flt = 1'b0;
        sh_idx  = '0;
        wd_idx  = '0;
        pmask   = '0;
        if (addr[63]) begin
            win     = WIN_D64;
            rng_flt = (addr[60:54] != 7'd0);
        end else if (addr[62:32] == 31'd0) begin
            if (addr[31]) begin
                win = WIN_D32;
            end else begin
                win     = WIN_M32;
                pmask   = M32_MASK;
                sh_idx  = SH_IDX_W'(SUPER_ENTRIES + int'(m32_pg));
                rng_flt = (int'(m32_pg) >= M32_ENTRIES);
            end
        end else if (addr[62:40] == 23'd0) begin
            if (addr[39]) begin
                win    = WIN_M40S;
                pmask  = SUPER_MASK;
                sh_idx = SH_IDX_W'({port, sup_pg});
            end else if (addr[38]) begin
                win     = WIN_M40;
                pmask   = M40_MASK;
                wd_idx  = WD_IDX_W'(m40_pg);
                rng_flt = (int'(m40_pg) >= M40_ENTRIES);
            end
        end
    end

    assign offset = addr & pmask;

endmodule

// File: rtl/inx_tables.sv
module inx_tables
    import inx_pkg::*;
#(
    parameter int SH_DEPTH = 128,
    parameter int WD_DEPTH = 64,
    parameter int SH_IDX_W = 7,
    parameter int WD_IDX_W = 6,
    parameter int IDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_tgt,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [63:0]         wr_data,
    input  logic [SH_IDX_W-1:0] sh_ridx,
    input  logic [WD_IDX_W-1:0] wd_ridx,
    input  logic                port_r,
    output logic [63:0]         sh_rdata,
    output logic [63:0]         wd_rdata,
    output logic [63:0]         dm_rdata
);

    logic [63:0] sh_q [SH_DEPTH];
    logic [63:0] wd_q [WD_DEPTH];
    logic [63:0] dm_q [2];

    logic we_sh, we_wd, we_dm;
    assign we_sh = wr_en && (wr_tgt == TGT_NARROW);
    assign we_wd = wr_en && (wr_tgt == TGT_WIDE);
    assign we_dm = wr_en && (wr_tgt == TGT_BASE);

    for (genvar i = 0; i < SH_DEPTH; i++) begin : g_sh
        always_ff @(posedge clk) begin
            if (!rst_n)                                  sh_q[i] <= '0;
            else if (we_sh && (32'(wr_idx) == i))        sh_q[i] <= wr_data;
        end
    end

    for (genvar i = 0; i < WD_DEPTH; i++) begin : g_wd
        always_ff @(posedge clk) begin
            if (!rst_n)                                  wd_q[i] <= '0;
            else if (we_wd && (32'(wr_idx) == i))        wd_q[i] <= wr_data;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_dm
        always_ff @(posedge clk) begin
            if (!rst_n)                                  dm_q[i] <= '0;
            else if (we_dm && (wr_idx[0] == 1'(i)))      dm_q[i] <= wr_data;
        end
    end

    assign sh_rdata = (32'(sh_ridx) < SH_DEPTH) ? sh_q[sh_ridx] : '0;
    assign wd_rdata = (32'(wd_ridx) < WD_DEPTH) ? wd_q[wd_ridx] : '0;
    assign dm_rdata = dm_q[port_r];

endmodule

// File: rtl/dma_inbound_xlate.sv
module dma_inbound_xlate
    import inx_pkg::*;
#(
    parameter int M32_ENTRIES = 64,
    parameter int M40_ENTRIES = 64,
    localparam int SH_DEPTH   = SUPER_ENTRIES + M32_ENTRIES,
    localparam int SH_IDX_W   = $clog2(SH_DEPTH),
    localparam int WD_IDX_W   = $clog2(M40_ENTRIES),
    localparam int IDX_W      = (SH_IDX_W > WD_IDX_W) ? SH_IDX_W : WD_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_port,
    input  logic [63:0]      req_addr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [63:0]      rsp_addr,
    output logic             rsp_barrier,
    output logic             rsp_msi,
    output logic             rsp_fault,
    input  logic             wr_en,
    input  logic [1:0]       wr_tgt,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data
);

    win_e                win;
    logic                rng_flt;
    logic [SH_IDX_W-1:0] sh_idx;
    logic [WD_IDX_W-1:0] wd_idx;
    logic [63:0]         offset, pmask;
    logic [63:0]         sh_rd, wd_rd, dm_rd;

    inx_decode #(
        .M32_ENTRIES(M32_ENTRIES),
        .M40_ENTRIES(M40_ENTRIES),
        .SH_IDX_W   (SH_IDX_W),
        .WD_IDX_W   (WD_IDX_W)
    ) u_dec (
        .addr   (req_addr),
        .port   (req_port),
        .win    (win),
        .rng_flt(rng_flt),
        .sh_idx (sh_idx),
        .wd_idx (wd_idx),
        .offset (offset),
        .pmask  (pmask)
    );

    inx_tables #(
        .SH_DEPTH(SH_DEPTH),
        .WD_DEPTH(M40_ENTRIES),
        .SH_IDX_W(SH_IDX_W),
        .WD_IDX_W(WD_IDX_W),
        .IDX_W   (IDX_W)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_tgt  (wr_tgt),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sh_ridx (sh_idx),
        .wd_ridx (wd_idx),
        .port_r  (req_port),
        .sh_rdata(sh_rd),
        .wd_rdata(wd_rd),
        .dm_rdata(dm_rd)
    );

    rsp_s        st_d, st_q;
    rsp_s        res;
    logic [63:0] ent, pg;
    logic        accept;

    assign req_ready = !st_q.vld || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        res     = '0;
        res.vld = 1'b1;
        ent     = (win == WIN_M40) ? wd_rd : sh_rd;
        pg      = {10'd0, ent[53:0]} & ~pmask;
        case (win)
            WIN_D64: begin
                res.addr = {10'd0, req_addr[53:0]};
                res.bar  = req_addr[62];
                res.msi  = req_addr[61];
                res.flt  = rng_flt;
            end
            WIN_D32: begin
                res.addr = {dm_rd[63:30], req_addr[29:0]};
                res.bar  = req_addr[30];
                res.flt  = (dm_rd[63:30] == 34'd0);
            end
            WIN_M32: begin
                res.addr = pg | offset;
                res.bar  = req_addr[30];
                res.flt  = rng_flt || !ent[63];
            end
            WIN_M40, WIN_M40S: begin
                res.addr = pg | offset;
                res.flt  = rng_flt || !ent[63];
            end
            default: res.flt = 1'b1;
        endcase
        if (res.flt) begin
            res.addr = '0;
            res.bar  = 1'b0;
            res.msi  = 1'b0;
        end

        st_d = st_q;
        if (accept)         st_d = res;
        else if (rsp_ready) st_d.vld = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.vld;
    assign rsp_addr    = st_q.addr;
    assign rsp_barrier = st_q.bar;
    assign rsp_msi     = st_q.msi;
    assign rsp_fault   = st_q.flt;

endmodule

// File: rtl/inx_chk.sv
module inx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [63:0] rsp_addr,
    input logic        rsp_barrier,
    input logic        rsp_msi,
    input logic        rsp_fault
);

    // R1
    accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R1
    ready_only_blocked_by_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (rsp_valid && !rsp_ready));

    // R1
    stalled_rsp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                       $stable(rsp_fault) && $stable(rsp_barrier)));

    // R2
    direct64_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr[63] && (req_addr[60:54] == 7'd0))
        |=> (rsp_addr == {10'd0, $past(req_addr[53:0])}) && !rsp_fault);

    // R5
    wide_no_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_addr[63:40] == 24'd0) && (req_addr[39:38] != 2'd0))
        |=> !rsp_barrier);

    // R8
    hole_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_addr[63] && (req_addr[62:40] != 23'd0))
        |=> rsp_fault);

    // R9
    fault_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ((rsp_addr == 64'd0) && !rsp_barrier && !rsp_msi));

endmodule

bind dma_inbound_xlate inx_chk u_chk (.*);

// File: tb/tb_dma_inbound_xlate.sv
module tb_dma_inbound_xlate;

    localparam int IDX_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, req_ready, req_port;
    logic [63:0]      req_addr;
    logic             rsp_valid, rsp_ready;
    logic [63:0]      rsp_addr;
    logic             rsp_barrier, rsp_msi, rsp_fault;
    logic             wr_en;
    logic [1:0]       wr_tgt;
    logic [IDX_W-1:0] wr_idx;
    logic [63:0]      wr_data;

    always #2.5 clk = ~clk;

    dma_inbound_xlate dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic        port;
        logic [63:0] a;
        logic [63:0] ea;
        logic        eb;
        logic        em;
        logic        ef;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'hC000_0000_1234_5678, 64'h0000_0000_1234_5678, 1'b1, 1'b0, 1'b0}, // R2
        '{1'b0, 64'hA03F_FFFF_FFFF_FFFF, 64'h003F_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0}, // R2
        '{1'b0, 64'h8040_0000_0000_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R2
        '{1'b0, 64'h0000_0000_C123_4567, 64'h0000_0012_C123_4567, 1'b1, 1'b0, 1'b0}, // R3
        '{1'b1, 64'h0000_0000_8000_0010, 64'h0,                   1'b0, 1'b0, 1'b1}, // R3
        '{1'b0, 64'h0000_0000_400C_1234, 64'h0000_0001_2344_1234, 1'b1, 1'b0, 1'b0}, // R4
        '{1'b0, 64'h0000_0000_0010_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R7
        '{1'b0, 64'h0000_0000_0100_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R4
        '{1'b0, 64'h0000_0040_0800_0055, 64'h0000_0000_0C00_0055, 1'b0, 1'b0, 1'b0}, // R5
        '{1'b0, 64'h0000_0040_1C00_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R7
        '{1'b0, 64'h0000_0041_0000_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R5
        '{1'b0, 64'h0000_0097_0000_0001, 64'h0000_0043_0000_0001, 1'b0, 1'b0, 1'b0}, // R6
        '{1'b1, 64'h0000_0084_0000_0010, 64'h0000_0080_0000_0010, 1'b0, 1'b0, 1'b0}, // R6
        '{1'b0, 64'h0000_0084_0000_0010, 64'h0,                   1'b0, 1'b0, 1'b1}, // R6
        '{1'b0, 64'h0000_0001_0000_0000, 64'h0,                   1'b0, 1'b0, 1'b1}, // R8
        '{1'b0, 64'h0000_0100_0000_0000, 64'h0,                   1'b0, 1'b0, 1'b1}  // R8
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R7", "R4",
                                    "R5", "R7", "R5", "R6", "R6", "R6", "R8", "R8"};

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] tgt, input int idx, input logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_tgt  = tgt;
        wr_idx  = IDX_W'(idx);
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic p, input logic [63:0] a,
                          input logic [63:0] ea, input logic eb, input logic em, input logic ef);
        @(negedge clk);
        req_valid = 1'b1;
        req_port  = p;
        req_addr  = a;
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"},   64'(rsp_valid),   64'd1);
        check({tag, " addr"},    rsp_addr,         ea);
        check({tag, " barrier"}, 64'(rsp_barrier), 64'(eb));
        check({tag, " msi"},     64'(rsp_msi),     64'(em));
        check({tag, " fault"},   64'(rsp_fault),   64'(ef));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_port  = 1'b0;
        req_addr  = '0;
        rsp_ready = 1'b1;
        wr_en     = 1'b0;
        wr_tgt    = '0;
        wr_idx    = '0;
        wr_data   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: idle outputs after reset
        check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R11 req_ready", 64'(req_ready), 64'd1);
        // R11: paged entry empty after reset
        lookup("R11 narrow entry", 1'b0, 64'h0000_0000_000C_0000, 64'h0, 1'b0, 1'b0, 1'b1);
        // R11: base register empty after reset
        lookup("R11 base reg", 1'b0, 64'h0000_0000_8000_0000, 64'h0, 1'b0, 1'b0, 1'b1);

        // R10: table load through the write port
        cfg_write(2'd0, 0,  64'h0000_0012_C000_0000);
        cfg_write(2'd1, 67, 64'h8000_0001_2344_0ABC);
        cfg_write(2'd1, 5,  64'h8000_0040_0000_0123);
        cfg_write(2'd1, 33, 64'h8000_0080_0000_0000);
        cfg_write(2'd2, 2,  64'h8000_0000_0C00_0000);
        cfg_write(2'd2, 7,  64'h0000_0000_1000_0000);

        for (int i = 0; i < NV; i++) begin
            lookup(VTAG[i], VECS[i].port, VECS[i].a, VECS[i].ea, VECS[i].eb, VECS[i].em, VECS[i].ef);
        end

        // R10: target code 3 changes nothing
        cfg_write(2'd3, 2, 64'h8000_0000_3000_0000);
        cfg_write(2'd3, 1, 64'h8000_0000_0000_0000);
        lookup("R10 ignored wide", 1'b0, 64'h0000_0040_0800_0055,
               64'h0000_0000_0C00_0055, 1'b0, 1'b0, 1'b0);
        lookup("R10 ignored narrow", 1'b0, 64'h0000_0084_0000_0010, 64'h0, 1'b0, 1'b0, 1'b1);

        // R10: write in the same cycle as a lookup of that entry
        @(negedge clk);
        wr_en     = 1'b1;
        wr_tgt    = 2'd1;
        wr_idx    = IDX_W'(67);
        wr_data   = 64'h8000_0002_0000_0000;
        req_valid = 1'b1;
        req_port  = 1'b0;
        req_addr  = 64'h0000_0000_000C_1234;
        @(posedge clk);
        @(negedge clk);
        wr_en     = 1'b0;
        req_valid = 1'b0;
        check("R10 same-cycle old value", rsp_addr, 64'h0000_0001_2344_1234);
        lookup("R10 next lookup new value", 1'b0, 64'h0000_0000_000C_1234,
               64'h0000_0002_0000_1234, 1'b0, 1'b0, 1'b0);

        // R3: second port base register selected by port
        cfg_write(2'd0, 1, 64'h0000_0003_4000_0000);
        lookup("R3 port1 base", 1'b1, 64'h0000_0000_8000_0010,
               64'h0000_0003_4000_0010, 1'b0, 1'b0, 1'b0);

        // R1: back-pressure, then drain and accept in one cycle
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 64'hC000_0000_1234_5678;
        rsp_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_addr = 64'h0000_0040_0800_0055;
        check("R1 stall valid", 64'(rsp_valid), 64'd1);
        check("R1 stall ready low", 64'(req_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R1 stall hold addr", rsp_addr, 64'h0000_0000_1234_5678);
        check("R1 stall hold barrier", 64'(rsp_barrier), 64'd1);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 drain+accept addr", rsp_addr, 64'h0000_0000_0C00_0055);
        check("R1 drain+accept valid", 64'(rsp_valid), 64'd1);
        @(posedge clk);
        @(negedge clk);
        check("R1 drained", 64'(rsp_valid), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule